// File: doc/BRIEF.md
# T1 Transmit Channel Formatter

This block sits in the transmit path of a 24-channel T1 framer. It takes the outgoing serial NRZ payload one bit per clock and rewrites each 8-bit channel word on the fly. Per channel it can substitute an idle code, force a ones-density bit into all-zero words, and rob the least significant bit for signaling in the signaling frames. On top of that it applies the yellow and blue alarm patterns. The framing-bit slot at the head of each 193-bit frame passes through untouched, except where an alarm pattern claims it.

A frame-sync pulse marks the framing-bit slot of the input stream. A free-running internal counter tracks the bit, the channel and the frame number within the superframe from there on. The whole-word tests need the complete channel word before its first bit can leave, so the payload comes out a fixed nine clocks after it went in. A marker output flags the cycles in which a framing bit is on the output. All control inputs are static configuration.

Top module: `t1_tx_fmt`

## Requirements
- R1: The bit sampled at a rising edge appears on `ser_out` after the eighth rising edge that follows that edge (nine clocks of latency). `out_fbit` is high exactly when `ser_out` carries a framing-bit slot. Both outputs are 0 while `rst_n` is low.
- R2: In a channel whose `idle_map` bit is set, the word is replaced by 0x7F when `idle_sel`=0 and by 0xFF when `idle_sel`=1. Bit 1 is the MSB and is sent first. Channel k (numbered from 1) takes the 8 bits that follow bit position 8(k-1) after the framing bit, and it is controlled by map bit k-1.
- R3: When `b7_en`=1, a non-clear channel whose word is all zeros after idle substitution is sent with bit 7 (the seventh bit sent) set to 1. The test is made before signaling insertion, so a word of zeros with only bit 8 set is not stuffed.
- R4: When `rbs_en`=1, bit 8 of every non-clear channel is replaced by the `sig_in` value sampled during that channel's bit-8 input time. This applies only in frames 6 and 12 of the 12-frame superframe (`ext_sf`=0), or frames 6, 12, 18 and 24 of the 24-frame superframe (`ext_sf`=1).
- R5: A channel whose `clear_map` bit is set gets neither stuffing nor signaling; its word is sent unchanged unless it is idle or an alarm applies.
- R6: A channel that is both idle and non-clear still has its bit 8 robbed in signaling frames. A channel that is idle and clear sends the bare idle code.
- R7: With `yel_en`=1, `yel_sbit`=0 and `ext_sf`=0, bit 2 of every channel is sent as 0. Framing bits are not affected.
- R8: With `yel_en`=1, `yel_sbit`=1 and `ext_sf`=0, the framing bit of frame 12 is sent as 1 and the payload is not affected. With `ext_sf`=1, `yel_en` has no effect on `ser_out`.
- R9: With `blue_en`=1, `ser_out` is 1 in every cycle, framing-bit slots included, whatever the other controls are.
- R10: Outside R8 and R9, the framing bit passes to `ser_out` unchanged: it is never idled, stuffed or robbed.
- R11: The first framing bit after reset starts frame 1. A `fsync` pulse in the middle of a frame makes that cycle a framing-bit slot that begins the next frame number, and the bit and channel positions restart from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | High in the cycle whose `ser_in` bit is a framing bit |
| ser_in | input | 1 | Serial NRZ payload in |
| sig_in | input | 1 | Robbed-bit signaling value, used at bit-8 times |
| ext_sf | input | 1 | 0: 12-frame superframe, 1: 24-frame superframe |
| idle_map | input | 24 | Per-channel idle select, bit k-1 for channel k |
| clear_map | input | 24 | Per-channel clear (transparent) select |
| idle_sel | input | 1 | Idle code: 0 gives 0x7F, 1 gives 0xFF |
| b7_en | input | 1 | Global bit-7 zero stuffing enable |
| rbs_en | input | 1 | Robbed-bit signaling enable |
| yel_en | input | 1 | Yellow alarm enable |
| yel_sbit | input | 1 | Yellow form for the 12-frame superframe: 0 bit-2 zero, 1 frame-12 S-bit |
| blue_en | input | 1 | Blue alarm (unframed all ones) |
| ser_out | output | 1 | Formatted serial output |
| out_fbit | output | 1 | High while `ser_out` carries a framing-bit slot |

## Verification
Every cycle, the assertions check the following. The output framing marker follows the input framing slot at the fixed latency. Blue alarm forces ones. In bit-2 yellow mode, bit 2 is driven low. A clear, non-idle channel sends its raw bit 8, and framing bits come through unchanged. Whether a word is stuffed, which frames are robbed, the value of the idle codes, the interplay of idle with signaling, the frame-12 S-bit and the frame renumbering after a mid-frame resync all depend on superframe position and whole-word content. Only the bench's reference model, run over full superframes in each mode, can show those.

// File: rtl/t1fmt_pkg.sv
package t1fmt_pkg;

  // Default geometry of a T1 frame
  localparam int T1_CHANNELS  = 24;
  localparam int T1_WORD_BITS = 8;
  localparam int T1_SF_SHORT  = 12;
  localparam int T1_SF_LONG   = 24;
  localparam int T1_SIG_EVERY = 6;

  // Idle pattern: all ones, with the MSB cleared when sel is 0
  function automatic logic [T1_WORD_BITS-1:0] idle_pattern(input logic sel);
    logic [T1_WORD_BITS-1:0] w;
    w = '1;
    w[T1_WORD_BITS-1] = sel;
    return w;
  endfunction

endpackage

// File: rtl/t1fmt_timing.sv
module t1fmt_timing
  import t1fmt_pkg::*;
#(
  parameter int N_CH      = T1_CHANNELS,
  parameter int CH_BITS   = T1_WORD_BITS,
  parameter int SF_SHORT  = T1_SF_SHORT,
  parameter int SF_LONG   = T1_SF_LONG,
  parameter int SIG_EVERY = T1_SIG_EVERY,
  localparam int BW = $clog2(CH_BITS),
  localparam int CW = $clog2(N_CH),
  localparam int FW = $clog2(SF_LONG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          ext_sf,
  output logic          in_f,
  output logic [BW-1:0] in_bsel,
  output logic [CW-1:0] in_ch,
  output logic          in_last,
  output logic          in_sigfr,
  output logic          in_s12
);

  logic          f_q, f_d;
  logic [BW-1:0] b_q, b_d;
  logic [CW-1:0] c_q, c_d;
  logic [FW-1:0] frm_q, frm_cur, last_frm;

  // Position of the bit presented in this cycle
  always_comb begin
    in_f     = fsync | f_q;
    in_bsel  = fsync ? '0 : b_q;
    in_ch    = fsync ? '0 : c_q;
    last_frm = ext_sf ? FW'(SF_LONG - 1) : FW'(SF_SHORT - 1);
    if (in_f)
      frm_cur = (frm_q >= last_frm) ? '0 : frm_q + FW'(1);
    else
      frm_cur = frm_q;
    in_last  = !in_f && (in_bsel == BW'(CH_BITS - 1));
    in_sigfr = ((32'(frm_cur) % SIG_EVERY) == (SIG_EVERY - 1));
    in_s12   = !ext_sf && (frm_cur == FW'(SF_SHORT - 1));
  end

  // Successor position
  always_comb begin
    f_d = 1'b0;
    b_d = in_bsel;
    c_d = in_ch;
    if (in_f) begin
      b_d = '0;
      c_d = '0;
    end else if (in_bsel == BW'(CH_BITS - 1)) begin
      b_d = '0;
      if (in_ch == CW'(N_CH - 1)) begin
        c_d = '0;
        f_d = 1'b1;
      end else begin
        c_d = in_ch + CW'(1);
      end
    end else begin
      b_d = in_bsel + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q   <= 1'b1;
      b_q   <= '0;
      c_q   <= '0;
      frm_q <= '1;
    end else begin
      f_q   <= f_d;
      b_q   <= b_d;
      c_q   <= c_d;
      frm_q <= frm_cur;
    end
  end

endmodule

// File: rtl/t1fmt_word.sv
module t1fmt_word
  import t1fmt_pkg::*;
#(
  parameter int N_CH    = T1_CHANNELS,
  parameter int CH_BITS = T1_WORD_BITS,
  localparam int CW = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  input  logic               sig_in,
  input  logic               in_f,
  input  logic               in_last,
  input  logic [CW-1:0]      in_ch,
  input  logic               in_sigfr,
  input  logic [N_CH-1:0]    idle_map,
  input  logic [N_CH-1:0]    clear_map,
  input  logic               idle_sel,
  input  logic               b7_en,
  input  logic               rbs_en,
  input  logic               yel_b2_on,
  output logic [CH_BITS-1:0] w_out,
  output logic               w_clear,
  output logic               w_idle
);

  logic [CH_BITS-2:0] acc_q, acc_d;
  logic               acc_en, cap_en;
  logic [CH_BITS-1:0] raw_q, raw_d;
  logic               clr_q, idl_q, sig_q, sfr_q;
  logic               clr_d, idl_d, sig_d, sfr_d;
  logic [CH_BITS-1:0] base_w, stuf_w, sig_w;

  // Collection of the word's first bits; capture at its last bit
  always_comb begin
    acc_en = !in_f;
    cap_en = in_last;
    acc_d  = {acc_q[CH_BITS-3:0], ser_in};
    raw_d  = {acc_q, ser_in};
    clr_d  = clear_map[in_ch];
    idl_d  = idle_map[in_ch];
    sig_d  = sig_in;
    sfr_d  = in_sigfr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      clr_q <= 1'b0;
      idl_q <= 1'b0;
      sig_q <= 1'b0;
      sfr_q <= 1'b0;
    end else if (cap_en) begin
      raw_q <= raw_d;
      clr_q <= clr_d;
      idl_q <= idl_d;
      sig_q <= sig_d;
      sfr_q <= sfr_d;
    end
  end

  // Insertion chain: idle, stuffing test, robbed bit, bit-2 yellow
  always_comb begin
    base_w = idl_q ? idle_pattern(idle_sel) : raw_q;
    stuf_w = base_w;
    if (b7_en && !clr_q && (base_w == '0))
      stuf_w[1] = 1'b1;
    sig_w = stuf_w;
    if (rbs_en && !clr_q && sfr_q)
      sig_w[0] = sig_q;
    w_out = sig_w;
    if (yel_b2_on)
      w_out[CH_BITS-2] = 1'b0;
  end

  assign w_clear = clr_q;
  assign w_idle  = idl_q;

endmodule

// File: rtl/t1fmt_outstage.sv
module t1fmt_outstage
  import t1fmt_pkg::*;
#(
  parameter int CH_BITS = T1_WORD_BITS,
  localparam int BW = $clog2(CH_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  input  logic               in_f,
  input  logic [BW-1:0]      in_bsel,
  input  logic               in_s12,
  input  logic [CH_BITS-1:0] w_out,
  input  logic               blue_en,
  input  logic               yel_s_on,
  output logic               st_f,
  output logic               st_bit,
  output logic [BW-1:0]      st_bsel,
  output logic               ser_out,
  output logic               out_fbit
);

  logic          d_bit  [CH_BITS];
  logic          d_f    [CH_BITS];
  logic          d_s12  [CH_BITS];
  logic [BW-1:0] d_bsel [CH_BITS];

  // One-word delay line carrying each bit with its position tag
  for (genvar i = 0; i < CH_BITS; i++) begin : g_stage
    logic          nb, nf, ns;
    logic [BW-1:0] nsel;
    if (i == 0) begin : g_head
      assign nb   = ser_in;
      assign nf   = in_f;
      assign ns   = in_s12;
      assign nsel = in_bsel;
    end else begin : g_body
      assign nb   = d_bit[i-1];
      assign nf   = d_f[i-1];
      assign ns   = d_s12[i-1];
      assign nsel = d_bsel[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_bit[i]  <= 1'b0;
        d_f[i]    <= 1'b0;
        d_s12[i]  <= 1'b0;
        d_bsel[i] <= '0;
      end else begin
        d_bit[i]  <= nb;
        d_f[i]    <= nf;
        d_s12[i]  <= ns;
        d_bsel[i] <= nsel;
      end
    end
  end

  // Word in transmit order: element 0 is the first bit sent
  logic [CH_BITS-1:0] w_tx;
  for (genvar j = 0; j < CH_BITS; j++) begin : g_rev
    assign w_tx[j] = w_out[CH_BITS-1-j];
  end

  logic out_d, fbit_d;

  always_comb begin
    st_f    = d_f[CH_BITS-1];
    st_bit  = d_bit[CH_BITS-1];
    st_bsel = d_bsel[CH_BITS-1];
    fbit_d  = st_f;
    if (blue_en)
      out_d = 1'b1;
    else if (st_f)
      out_d = st_bit | (yel_s_on & d_s12[CH_BITS-1]);
    else
      out_d = w_tx[st_bsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_out  <= 1'b0;
      out_fbit <= 1'b0;
    end else begin
      ser_out  <= out_d;
      out_fbit <= fbit_d;
    end
  end

endmodule

// File: rtl/t1_tx_fmt.sv
module t1_tx_fmt
  import t1fmt_pkg::*;
#(
  parameter int N_CH      = T1_CHANNELS,
  parameter int CH_BITS   = T1_WORD_BITS,
  parameter int SF_SHORT  = T1_SF_SHORT,
  parameter int SF_LONG   = T1_SF_LONG,
  parameter int SIG_EVERY = T1_SIG_EVERY
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fsync,
  input  logic            ser_in,
  input  logic            sig_in,
  input  logic            ext_sf,
  input  logic [N_CH-1:0] idle_map,
  input  logic [N_CH-1:0] clear_map,
  input  logic            idle_sel,
  input  logic            b7_en,
  input  logic            rbs_en,
  input  logic            yel_en,
  input  logic            yel_sbit,
  input  logic            blue_en,
  output logic            ser_out,
  output logic            out_fbit
);

  localparam int BW = $clog2(CH_BITS);
  localparam int CW = $clog2(N_CH);

  logic               in_f, in_last, in_sigfr, in_s12;
  logic [BW-1:0]      in_bsel;
  logic [CW-1:0]      in_ch;
  logic [CH_BITS-1:0] w_out;
  logic               w_clear, w_idle;
  logic               st_f, st_bit;
  logic [BW-1:0]      st_bsel;
  logic               yel_b2_on, yel_s_on;

  // Yellow forms exist only in the short superframe
  assign yel_b2_on = yel_en && !ext_sf && !yel_sbit;
  assign yel_s_on  = yel_en && !ext_sf &&  yel_sbit;

  t1fmt_timing #(
    .N_CH(N_CH), .CH_BITS(CH_BITS), .SF_SHORT(SF_SHORT),
    .SF_LONG(SF_LONG), .SIG_EVERY(SIG_EVERY)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .ext_sf(ext_sf),
    .in_f(in_f), .in_bsel(in_bsel), .in_ch(in_ch), .in_last(in_last),
    .in_sigfr(in_sigfr), .in_s12(in_s12)
  );

  t1fmt_word #(.N_CH(N_CH), .CH_BITS(CH_BITS)) u_word (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sig_in(sig_in),
    .in_f(in_f), .in_last(in_last), .in_ch(in_ch), .in_sigfr(in_sigfr),
    .idle_map(idle_map), .clear_map(clear_map), .idle_sel(idle_sel),
    .b7_en(b7_en), .rbs_en(rbs_en), .yel_b2_on(yel_b2_on),
    .w_out(w_out), .w_clear(w_clear), .w_idle(w_idle)
  );

  t1fmt_outstage #(.CH_BITS(CH_BITS)) u_out (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .in_f(in_f),
    .in_bsel(in_bsel), .in_s12(in_s12), .w_out(w_out),
    .blue_en(blue_en), .yel_s_on(yel_s_on),
    .st_f(st_f), .st_bit(st_bit), .st_bsel(st_bsel),
    .ser_out(ser_out), .out_fbit(out_fbit)
  );

endmodule

// File: rtl/t1fmt_chk.sv
module t1fmt_chk #(
  parameter int CH_BITS = 8,
  localparam int BW  = $clog2(CH_BITS),
  localparam int LAT = CH_BITS + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blue_en,
  input logic          yel_b2_on,
  input logic          yel_s_on,
  input logic          in_f,
  input logic          st_f,
  input logic          st_bit,
  input logic [BW-1:0] st_bsel,
  input logic          w_clear,
  input logic          w_idle,
  input logic          ser_out,
  input logic          out_fbit
);

  // Framing-slot history since reset
  logic [LAT-1:0] fhist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fhist <= '0;
    else        fhist <= {fhist[LAT-2:0], in_f};
  end

  p_fbit_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_fbit == fhist[LAT-1]);

  p_yellow_bit2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (yel_b2_on && !st_f && st_bsel == BW'(1) && !blue_en) |=> !ser_out);

  p_clear_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_f && st_bsel == BW'(CH_BITS - 1) && w_clear && !w_idle && !blue_en)
      |=> (ser_out == $past(st_bit)));

  p_blue_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blue_en |=> ser_out);

  p_fbit_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_f && !blue_en && !yel_s_on) |=> (ser_out == $past(st_bit)));

endmodule

bind t1_tx_fmt t1fmt_chk #(.CH_BITS(CH_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .blue_en(blue_en), .yel_b2_on(yel_b2_on),
  .yel_s_on(yel_s_on), .in_f(in_f), .st_f(st_f), .st_bit(st_bit),
  .st_bsel(st_bsel), .w_clear(w_clear), .w_idle(w_idle),
  .ser_out(ser_out), .out_fbit(out_fbit)
);

// File: tb/sim_t1_tx_fmt.sv
module sim_t1_tx_fmt;

  localparam int NCH  = 24;
  localparam int FB   = NCH * 8 + 1;
  localparam int LAT  = 9;
  localparam int MAXT = 6000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fsync, ser_in, sig_in, ext_sf, idle_sel, b7_en, rbs_en;
  logic yel_en, yel_sbit, blue_en, ser_out, out_fbit;
  logic [NCH-1:0] idle_map, clear_map;

  t1_tx_fmt u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .ser_in(ser_in), .sig_in(sig_in),
    .ext_sf(ext_sf), .idle_map(idle_map), .clear_map(clear_map),
    .idle_sel(idle_sel), .b7_en(b7_en), .rbs_en(rbs_en), .yel_en(yel_en),
    .yel_sbit(yel_sbit), .blue_en(blue_en), .ser_out(ser_out), .out_fbit(out_fbit)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit ev [MAXT];
  bit eb [MAXT];
  bit ef [MAXT];

  task automatic check(string tag, string what, int t, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s t=%0d actual=%b expected=%b", tag, what, t, act, exp);
    end
  endtask

  // Expected channel word from the requirements (R2..R7)
  function automatic logic [7:0] expect_word(logic [7:0] w, int ch, int frm, logic s);
    logic [7:0] r;
    bit clr = clear_map[ch];
    r = w;
    if (idle_map[ch]) r = idle_sel ? 8'hFF : 8'h7F;            // R2
    if (b7_en && !clr && r == 8'h00) r = 8'h02;                 // R3: bit 7 is 2nd LSB
    if (rbs_en && !clr && (frm % 6 == 5)) r[0] = s;             // R4, R5, R6
    if (yel_en && !ext_sf && !yel_sbit) r[6] = 1'b0;            // R7
    if (blue_en) r = 8'hFF;                                     // R9
    return r;
  endfunction

  task automatic run_phase(string tag, int frames, int realign_at);
    int nf, mfrm, mpos, total, wstart;
    logic [7:0] cur, acc;
    rst_n = 1'b0; fsync = 1'b0; ser_in = 1'b0; sig_in = 1'b0;
    repeat (3) @(negedge clk);
    check({tag, " R1 reset"}, "ser_out", 0, ser_out, 1'b0);
    check({tag, " R1 reset"}, "out_fbit", 0, out_fbit, 1'b0);
    for (int i = 0; i < MAXT; i++) ev[i] = 1'b0;
    nf = ext_sf ? 24 : 12;
    mfrm = nf - 1; mpos = 0; total = frames * FB; wstart = -100;
    cur = 8'h00; acc = 8'h00;
    for (int t = 0; t < total + LAT + 1; t++) begin
      @(negedge clk);
      if (t == 0) rst_n = 1'b1;
      if (t >= LAT && ev[t-LAT]) begin
        check(tag, "ser_out", t - LAT, ser_out, eb[t-LAT]);
        check(tag, "out_fbit", t - LAT, out_fbit, ef[t-LAT]);
      end
      if (t < total) begin
        int pos;
        fsync  = (t == 0) || (t == realign_at);
        sig_in = 1'($urandom_range(0, 1));
        pos = fsync ? 0 : mpos;
        if (pos == 0) begin
          mfrm = (mfrm + 1) % nf;                               // R11
          ser_in = 1'($urandom_range(0, 1));
          ev[t] = 1'b1; ef[t] = 1'b1;
          eb[t] = blue_en ? 1'b1 :
                  (ser_in | (yel_en && !ext_sf && yel_sbit && mfrm == 11)); // R8, R10
        end else begin
          int b, ch;
          b = (pos - 1) % 8; ch = (pos - 1) / 8;
          if (b == 0) begin
            int k;
            k = $urandom_range(0, 5);
            cur = (k < 2) ? 8'h00 : (k == 2) ? 8'h01 : 8'($urandom);
            wstart = t;
          end
          ser_in = cur[7-b];
          acc = {acc[6:0], ser_in};
          if (b == 7 && wstart == t - 7) begin
            logic [7:0] o;
            o = expect_word(acc, ch, mfrm, sig_in);
            for (int i = 0; i < 8; i++) begin
              ev[t-7+i] = 1'b1; ef[t-7+i] = 1'b0; eb[t-7+i] = o[7-i];
            end
          end
        end
        mpos = (pos == FB - 1) ? 0 : pos + 1;
      end else begin
        fsync = 1'b0;
      end
    end
  endtask

  task automatic set_ctrl(bit ext, bit isel, bit b7, bit rbs, bit yel, bit ysb, bit blue,
                          logic [NCH-1:0] imap, logic [NCH-1:0] cmap);
    ext_sf = ext; idle_sel = isel; b7_en = b7; rbs_en = rbs; yel_en = yel;
    yel_sbit = ysb; blue_en = blue; idle_map = imap; clear_map = cmap;
  endtask

  initial begin
    set_ctrl(0, 0, 0, 0, 0, 0, 0, '0, '0);
    // R1, R10: plain pass-through with latency
    run_phase("R1/R10 passthrough", 4, -1);
    // R2: idle codes in both forms
    set_ctrl(0, 0, 0, 0, 0, 0, 0, 24'hF0_0C31, '0);
    run_phase("R2 idle 7F", 3, -1);
    set_ctrl(0, 1, 1, 0, 0, 0, 0, 24'h0F_A108, 24'h00_0100);
    run_phase("R2 idle FF", 3, -1);
    // R3, R5: stuffing, with some clear channels
    set_ctrl(0, 0, 1, 0, 0, 0, 0, 24'h00_0001, 24'h81_2400);
    run_phase("R3/R5 stuffing", 3, -1);
    // R4, R5, R6: signaling in the 12-frame superframe
    set_ctrl(0, 0, 1, 1, 0, 0, 0, 24'h30_0C03, 24'h20_4802);
    run_phase("R4/R5/R6 signaling 12", 13, -1);
    // R4: signaling in the 24-frame superframe
    set_ctrl(1, 1, 1, 1, 0, 0, 0, 24'h00_F000, 24'h0C_1000);
    run_phase("R4/R6 signaling 24", 25, -1);
    // R7: bit-2 yellow
    set_ctrl(0, 0, 1, 1, 1, 0, 0, 24'h00_0300, '0);
    run_phase("R7 yellow bit2", 13, -1);
    // R8: S-bit yellow, then no effect in the long superframe
    set_ctrl(0, 0, 0, 0, 1, 1, 0, '0, '0);
    run_phase("R8 yellow sbit", 13, -1);
    set_ctrl(1, 0, 0, 0, 1, 0, 0, '0, '0);
    run_phase("R8 yellow ignored 24", 13, -1);
    // R9: blue overrides everything
    set_ctrl(0, 1, 1, 1, 1, 1, 1, 24'hFF_00FF, 24'h0F_0F0F);
    run_phase("R9 blue", 3, -1);
    // R11: mid-frame resync renumbers frames
    set_ctrl(0, 0, 1, 1, 0, 0, 0, 24'h00_0010, '0);
    run_phase("R11 resync", 13, 3 * FB + 53);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule